// File: doc/BRIEF.md
# Serial-In Latched Output Controller

This block is the digital front end of a bank of low-side output switches. A serial bit stream enters a chain of shift stages, one stage per clock. The last stage drives a serial output, so several controllers can be chained into a longer string. A strobe-controlled holding stage copies the shift chain into a parallel channel vector.

An active-low enable and a per-channel fault mask gate that vector before it reaches the drivers. Neither one changes any stored bit. A clear input feeds zeros into the chain through the normal shift path. Those zeros reach the outputs only after a strobe.

All state sits in flip-flops clocked by `clk`. Reset is synchronous and active-high. The channel vector is registered.

Top module: `sipo_drive_ctrl`

## Requirements
- R1: On each rising `clk` edge with `clr` low, stage 1 (bit 0 of the chain) takes `ser_in`, and every stage k takes the old value of stage k-1.
- R2: `ser_out` equals the last stage (bit CHANNELS-1). A bit entered at one edge appears on `ser_out` after CHANNELS-1 further edges.
- R3: On each edge with `clr` high, stage 1 takes 0 whatever `ser_in` is, and the rest of the chain still shifts.
- R4: `clr` does not alter the holding stage or `chan_on`. Cleared chain contents reach the outputs only through a strobe.
- R5: On each edge with `stb` high, the holding stage loads the chain contents present just before that edge.
- R6: On each edge with `stb` low, the holding stage keeps its value.
- R7: While `oe_n` is sampled high, `chan_on` is all zeros on the next cycle, and neither the holding stage nor the chain changes because of it. When `oe_n` returns low, the held pattern reappears.
- R8: With `oe_n` low, `chan_on[i]` (1 = channel sinks current) equals holding-stage bit i, one cycle after that bit is held. Bit i corresponds to stage i+1.
- R9: A 1 in `fault_mask[i]` sampled at an edge forces `chan_on[i]` to 0 after that edge. The other channels are unaffected.
- R10: While `rst` is high, the chain, the holding stage and `chan_on` are cleared to zero at each edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift and system clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial data into stage 1 |
| clr | input | 1 | Shift zeros instead of `ser_in` |
| stb | input | 1 | Holding stage loads the chain while high |
| oe_n | input | 1 | Active-low output enable |
| fault_mask | input | CHANNELS | Per-channel force-off |
| ser_out | output | 1 | Last chain stage, for cascading |
| chan_on | output | CHANNELS | Gated channel drive vector |

## Verification
The bench steps a cycle-accurate reference model and compares `ser_out` and `chan_on` after every edge.

An asymmetric pattern exposes a reversed shift direction. A reversed chain or a wrong tap would put `ser_out` out of step with the bits entered CHANNELS-1 edges earlier.

Clear is driven with the strobe low. A design that let clear act directly on the holding stage would drop the outputs early. Long runs with the strobe low would show a holding stage that leaks.

The enable is toggled off and back on. A design that cleared state on disable would fail to restore the pattern. Single mask bits are set to catch a mask that is inverted or applied to the wrong channels.

// File: rtl/sipo_drive_pkg.sv
package sipo_drive_pkg;
  localparam int DEF_CHANNELS = 8;

  typedef struct packed {
    logic clr;
    logic stb;
    logic oe_n;
  } ctrl_t;
endpackage

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain #(
  parameter int CHANNELS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ser_in,
  input  logic                clr,
  output logic [CHANNELS-1:0] stages
);
  localparam int TOP = CHANNELS - 1;

  logic entry_bit;

  assign entry_bit = clr ? 1'b0 : ser_in;

  always_ff @(posedge clk) begin
    if (rst) stages <= '0;
    else     stages <= {stages[TOP-1:0], entry_bit};
  end

  p_entry_r1: assert property (@(posedge clk) disable iff (rst)
    !clr |=> stages[0] == $past(ser_in));
  p_chain_moves_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> stages[TOP:1] == $past(stages[TOP-1:0]));
  p_clear_zero_r3: assert property (@(posedge clk) disable iff (rst)
    clr |=> stages[0] == 1'b0);
endmodule

// File: rtl/sipo_hold_gate.sv
module sipo_hold_gate #(
  parameter int CHANNELS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CHANNELS-1:0] chain,
  input  logic                stb,
  input  logic                oe_n,
  input  logic [CHANNELS-1:0] fault_mask,
  output logic [CHANNELS-1:0] held,
  output logic [CHANNELS-1:0] chan_on
);
  logic [CHANNELS-1:0] enable_vec;

  assign enable_vec = {CHANNELS{~oe_n}} & ~fault_mask;

  always_ff @(posedge clk) begin
    if (rst)      held <= '0;
    else if (stb) held <= chain;
  end

  genvar g;
  generate
    for (g = 0; g < CHANNELS; g++) begin : g_out
      always_ff @(posedge clk) begin
        if (rst) chan_on[g] <= 1'b0;
        else     chan_on[g] <= held[g] & enable_vec[g];
      end
    end
  endgenerate

  p_load_r5: assert property (@(posedge clk) disable iff (rst)
    stb |=> held == $past(chain));
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(held));
  p_disabled_off_r7: assert property (@(posedge clk) disable iff (rst)
    oe_n |=> chan_on == '0);
  p_masked_off_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (chan_on & $past(fault_mask)) == '0);
  p_no_spurious_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (chan_on & ~$past(held)) == '0);
endmodule

// File: rtl/sipo_drive_ctrl.sv
module sipo_drive_ctrl
  import sipo_drive_pkg::*;
#(
  parameter int CHANNELS = DEF_CHANNELS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ser_in,
  input  logic                clr,
  input  logic                stb,
  input  logic                oe_n,
  input  logic [CHANNELS-1:0] fault_mask,
  output logic                ser_out,
  output logic [CHANNELS-1:0] chan_on
);
  localparam int LAST = CHANNELS - 1;

  ctrl_t               ctl;
  logic [CHANNELS-1:0] chain;
  logic [CHANNELS-1:0] held;

  assign ctl = '{clr: clr, stb: stb, oe_n: oe_n};

  sipo_shift_chain #(.CHANNELS(CHANNELS)) u_chain (
    .clk    (clk),
    .rst    (rst),
    .ser_in (ser_in),
    .clr    (ctl.clr),
    .stages (chain)
  );

  sipo_hold_gate #(.CHANNELS(CHANNELS)) u_gate (
    .clk        (clk),
    .rst        (rst),
    .chain      (chain),
    .stb        (ctl.stb),
    .oe_n       (ctl.oe_n),
    .fault_mask (fault_mask),
    .held       (held),
    .chan_on    (chan_on)
  );

  assign ser_out = chain[LAST];

  p_clear_keeps_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (clr && !stb) |=> $stable(held));
  p_cascade_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ser_out == $past(chain[LAST-1]));
endmodule

// File: tb/sipo_drive_ctrl_test.sv
module sipo_drive_ctrl_test;
  localparam int N = 8;
  localparam time PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst, ser_in, clr, stb, oe_n;
  logic [N-1:0] fault_mask;
  logic ser_out;
  logic [N-1:0] chan_on;

  typedef struct {
    logic         so;
    logic [N-1:0] on;
    string        tag;
  } item_t;

  item_t q[$];
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [N-1:0] m_sr = '0, m_lat = '0, m_on = '0;

  always #(PERIOD/2) clk = ~clk;

  sipo_drive_ctrl #(.CHANNELS(N)) uut (
    .clk(clk), .rst(rst), .ser_in(ser_in), .clr(clr), .stb(stb),
    .oe_n(oe_n), .fault_mask(fault_mask), .ser_out(ser_out), .chan_on(chan_on)
  );

  task automatic step(input logic r, input logic si, input logic c, input logic s,
                      input logic o, input logic [N-1:0] m, input string tag);
    logic [N-1:0] n_sr, n_lat, n_on;
    item_t it;
    @(negedge clk);
    rst = r; ser_in = si; clr = c; stb = s; oe_n = o; fault_mask = m;
    if (r) begin
      n_sr = '0; n_lat = '0; n_on = '0;
    end else begin
      n_sr  = {m_sr[N-2:0], c ? 1'b0 : si};
      n_lat = s ? m_sr : m_lat;
      n_on  = m_lat & ~m & {N{~o}};
    end
    m_sr = n_sr; m_lat = n_lat; m_on = n_on;
    it.so = n_sr[N-1]; it.on = n_on; it.tag = tag;
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t e;
      e = q.pop_front();
      total++;
      if (ser_out !== e.so || chan_on !== e.on) begin
        bad++;
        $display("FAIL %s: ser_out=%b chan_on=%b expected ser_out=%b chan_on=%b",
                 e.tag, ser_out, chan_on, e.so, e.on);
      end
    end
  end

  initial begin
    #(PERIOD * 50000);
    if (!done) begin
      done = 1'b1;
      bad++;
      total++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] pat;
    rst = 1'b1; ser_in = 1'b0; clr = 1'b0; stb = 1'b0; oe_n = 1'b0; fault_mask = '0;
    // R10: reset state
    step(1, 1, 0, 1, 0, '0, "R10");
    step(1, 1, 0, 1, 0, '0, "R10");
    // R1 / R2 / R6: shift an asymmetric pattern with strobe low
    pat = 8'b1011_0010;
    for (int i = 0; i < N; i++) step(0, pat[N-1-i], 0, 0, 0, '0, "R1");
    // R5: one strobe cycle loads the chain, then R8 output appears
    step(0, 0, 0, 1, 0, '0, "R5");
    step(0, 0, 0, 0, 0, '0, "R8");
    // R6: keep shifting with strobe low, outputs must hold
    for (int i = 0; i < 6; i++) step(0, i[0], 0, 0, 0, '0, "R6");
    // R7: disable, then re-enable restores the held pattern
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 1, '0, "R7");
    for (int i = 0; i < 2; i++) step(0, 0, 0, 0, 0, '0, "R7");
    // R9: single and multiple mask bits
    step(0, 1, 0, 0, 0, 8'b0000_0010, "R9");
    step(0, 1, 0, 0, 0, 8'b1010_0000, "R9");
    step(0, 0, 0, 0, 0, 8'b1111_1111, "R9");
    step(0, 0, 0, 0, 0, '0, "R9");
    // R3 / R4: clear with strobe low, outputs unchanged, ser_in ignored
    for (int i = 0; i < N; i++) step(0, 1, 1, 0, 0, '0, "R4");
    // R3: strobe passes the cleared chain to the outputs
    step(0, 1, 1, 1, 0, '0, "R3");
    step(0, 1, 0, 0, 0, '0, "R3");
    step(0, 0, 0, 0, 0, '0, "R3");
    // R2: cascade stream and transparent strobe
    pat = 8'b1100_1011;
    for (int i = 0; i < 2 * N; i++) step(0, pat[i % N], 0, 1, 0, '0, "R2");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, '0, "R8");
    // R10: reset in mid-run
    step(1, 1, 0, 1, 0, '0, "R10");
    step(0, 0, 0, 0, 0, '0, "R10");
    repeat (3) @(posedge clk);
    #2;
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule